// File: doc/BRIEF.md
# Block Write-Protection Check and Cycle Enable Sequencer

This block sits between an address translator and the processor's bus cycle control. On every access it holds the processor's cycle-enable low until every configured check has finished. With translation configured, it waits for the translator to report a validated result. With protection configured, it looks up a write-protect bit for the 16K-word physical block that the access falls in. If either check fails, the enable is never raised, so the processor's bus cycle times out.

The protect bits live in a 64-entry one-bit table, indexed by the top six bits of the 20-bit physical address. A host loads the table through a dedicated write port. A one-entry cache holds the block index and protect bit of the block looked up last. A lookup that hits the cache decides in one cycle. A lookup in a different block costs one extra wait cycle while the cache refills from the table. Any table write invalidates the cache.

Two strap inputs select the configuration: translation only, protection only, both, or neither. An active-low valid flag reports that the protection result is ready. A second enable output qualifies the raw enable with that flag, so the processor never sees a pulse in the gap between the two results.

The sequencer is a Moore state machine with six states:
- IDLE: no access.
- XWAIT: waiting for translation.
- LOOKUP: cache check.
- REFILL: a cache miss. The decision comes straight from the table while the cache loads.
- GRANT: the access is enabled.
- DENY: the access is held off.

Its transitions are:
- start: IDLE goes to XWAIT, LOOKUP or GRANT, depending on the configuration.
- xlat_ok: XWAIT goes to LOOKUP, or to GRANT when protection is off.
- xlat_bad: goes to DENY from XWAIT, LOOKUP or REFILL.
- hit: LOOKUP goes to GRANT or DENY.
- miss: LOOKUP goes to REFILL.
- fill: REFILL goes to GRANT or DENY.
- end: any state goes to IDLE when the strobe is low.

Top module: `blkprot_gate`

## Requirements
- R1: After reset, `cyc_en` and `cyc_en_gated` are 0, `prot_valid_n` is 1, the cache is invalid and every table bit is 0.
- R2: While `addr_strb` is 0, `cyc_en` and `cyc_en_gated` are 0 in the same cycle, whatever the state.
- R3: With translation only (`cfg_xlat_on`=1, `cfg_prot_on`=0), `cyc_en` rises on the clock edge after the one that samples `xl_done`=1 with `xl_err`=0. If `xl_err` is 1 before the grant, `cyc_en` stays 0 for the rest of the access.
- R4: The table entry for an access is selected by `paddr[19:14]`. A pulse of `tbl_we` stores `tbl_bit` at `tbl_idx`, where 1 means write-protected. Every table write invalidates the cache, so the next lookup misses.
- R5: With protection only, a cache hit raises `cyc_en` on the second clock edge after `addr_strb` rises.
- R6: A cache miss is either an invalid cache or a different block index. It adds exactly one wait cycle, so with protection only `cyc_en` rises on the third edge.
- R7: Protection applies to writes only (`wr`=1). A write to a protected block keeps `cyc_en` at 0 for the whole access. A read of a protected block is granted.
- R8: With both checks configured, the protection lookup starts only after the translation is validated, and `cyc_en` rises only after that lookup passes. A bad translation ends in DENY without a lookup, and `prot_valid_n` stays 1.
- R9: `prot_valid_n` falls on the edge at which the protection decision is made (GRANT or DENY entered from LOOKUP or REFILL). It returns to 1 after the strobe drops, and stays 1 whenever `cfg_prot_on` is 0.
- R10: `cyc_en_gated` is `cyc_en` qualified by `prot_valid_n`=0 when protection is configured, and equals `cyc_en` otherwise.
- R11: With neither check configured, `cyc_en` rises on the first edge after `addr_strb` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_xlat_on | input | 1 | Strap: translation result is awaited |
| cfg_prot_on | input | 1 | Strap: block protection check is performed |
| addr_strb | input | 1 | Access in progress, high for the whole access |
| paddr | input | 20 | Physical address, stable while the strobe is high |
| wr | input | 1 | Access is a write |
| xl_done | input | 1 | Translation validated |
| xl_err | input | 1 | Translation erroneous |
| tbl_we | input | 1 | Protect-table write strobe |
| tbl_idx | input | 6 | Protect-table entry to write |
| tbl_bit | input | 1 | Protect bit to store |
| prot_valid_n | output | 1 | Protection result valid, active low |
| cyc_en | output | 1 | Raw cycle enable |
| cyc_en_gated | output | 1 | Cycle enable qualified by protection-valid |

## Verification
All results come from the state register, so each one is due a whole number of edges after the strobe rises:
- neither check: 1 edge
- translation only: 2 edges
- protection only, cache hit: 2 edges
- protection only, cache miss: 3 edges
- both checks: 3 edges on a hit, 4 on a miss

The one exception is the strobe-low forcing, which is combinational and is checked 1 ns after the strobe falls. Inputs are driven on the falling edge, and after every rising edge the outputs are sampled on the next falling edge. The checks therefore confirm that the enable is 0 at every edge before the due edge and 1 from the due edge on, or 0 throughout for denials.

// File: rtl/blkprot_pkg.sv
`timescale 1ns/1ps
package blkprot_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_XWAIT  = 3'd1,
        ST_LOOKUP = 3'd2,
        ST_REFILL = 3'd3,
        ST_GRANT  = 3'd4,
        ST_DENY   = 3'd5
    } bp_state_e;
endpackage

// File: rtl/blkprot_table.sv
`timescale 1ns/1ps
module blkprot_table #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic             wbit,
    input  logic [IDX_W-1:0] ridx,
    output logic             rbit
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] bits_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (we) begin
            bits_q[widx] <= wbit;
        end
    end

    assign rbit = bits_q[ridx];
endmodule

// File: rtl/blkprot_cache.sv
`timescale 1ns/1ps
module blkprot_cache #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inval,
    input  logic             load,
    input  logic [IDX_W-1:0] load_tag,
    input  logic             load_bit,
    input  logic [IDX_W-1:0] look_tag,
    output logic             hit,
    output logic             pbit
);
    logic             vld_q;
    logic [IDX_W-1:0] tag_q;
    logic             bit_q;

    // Invalidation wins over a refill in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            tag_q <= '0;
            bit_q <= 1'b0;
        end else if (inval) begin
            vld_q <= 1'b0;
        end else if (load) begin
            vld_q <= 1'b1;
            tag_q <= load_tag;
            bit_q <= load_bit;
        end
    end

    assign hit  = vld_q && (tag_q == look_tag);
    assign pbit = bit_q;
endmodule

// File: rtl/blkprot_fsm.sv
`timescale 1ns/1ps
module blkprot_fsm
    import blkprot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xlat_on,
    input  logic prot_on,
    input  logic strb,
    input  logic is_wr,
    input  logic xl_done,
    input  logic xl_err,
    input  logic c_hit,
    input  logic c_pbit,
    input  logic t_pbit,
    output logic cache_load,
    output logic grant,
    output logic pv
);
    bp_state_e state_q, state_d;
    logic      pv_q, pv_d;
    logic      bad_xlat;
    logic      chk_decide;

    assign bad_xlat = xlat_on && xl_err;

    // Next-state logic
    always_comb begin
        state_d    = state_q;
        chk_decide = 1'b0;
        if (!strb) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (xlat_on)      state_d = ST_XWAIT;
                    else if (prot_on) state_d = ST_LOOKUP;
                    else              state_d = ST_GRANT;
                end
                ST_XWAIT: begin
                    if (bad_xlat)     state_d = ST_DENY;
                    else if (xl_done) state_d = prot_on ? ST_LOOKUP : ST_GRANT;
                end
                ST_LOOKUP: begin
                    if (bad_xlat) begin
                        state_d = ST_DENY;
                    end else if (c_hit) begin
                        chk_decide = 1'b1;
                        state_d    = (is_wr && c_pbit) ? ST_DENY : ST_GRANT;
                    end else begin
                        state_d = ST_REFILL;
                    end
                end
                ST_REFILL: begin
                    if (bad_xlat) begin
                        state_d = ST_DENY;
                    end else begin
                        chk_decide = 1'b1;
                        state_d    = (is_wr && t_pbit) ? ST_DENY : ST_GRANT;
                    end
                end
                ST_GRANT: state_d = ST_GRANT;
                ST_DENY:  state_d = ST_DENY;
                default:  state_d = ST_IDLE;
            endcase
        end
        pv_d = strb && (pv_q || chk_decide);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pv_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            pv_q    <= pv_d;
        end
    end

    // Outputs
    always_comb begin
        cache_load = (state_q == ST_REFILL);
        grant      = (state_q == ST_GRANT);
        pv         = pv_q;
    end
endmodule

// File: rtl/blkprot_gate.sv
`timescale 1ns/1ps
module blkprot_gate #(
    parameter int PADDR_W = 20,
    parameter int IDX_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_xlat_on,
    input  logic               cfg_prot_on,
    input  logic               addr_strb,
    input  logic [PADDR_W-1:0] paddr,
    input  logic               wr,
    input  logic               xl_done,
    input  logic               xl_err,
    input  logic               tbl_we,
    input  logic [IDX_W-1:0]   tbl_idx,
    input  logic               tbl_bit,
    output logic               prot_valid_n,
    output logic               cyc_en,
    output logic               cyc_en_gated
);
    localparam int LOW_W = PADDR_W - IDX_W;

    logic [IDX_W-1:0] blk_idx;
    logic             unused_low;
    logic             tbl_rbit;
    logic             c_hit;
    logic             c_pbit;
    logic             cache_load;
    logic             grant;
    logic             pv;

    assign blk_idx    = paddr[PADDR_W-1 -: IDX_W];
    assign unused_low = ^paddr[LOW_W-1:0];

    blkprot_table #(.IDX_W(IDX_W)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .widx  (tbl_idx),
        .wbit  (tbl_bit),
        .ridx  (blk_idx),
        .rbit  (tbl_rbit)
    );

    blkprot_cache #(.IDX_W(IDX_W)) u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .inval    (tbl_we),
        .load     (cache_load),
        .load_tag (blk_idx),
        .load_bit (tbl_rbit),
        .look_tag (blk_idx),
        .hit      (c_hit),
        .pbit     (c_pbit)
    );

    blkprot_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .xlat_on    (cfg_xlat_on),
        .prot_on    (cfg_prot_on),
        .strb       (addr_strb),
        .is_wr      (wr),
        .xl_done    (xl_done),
        .xl_err     (xl_err),
        .c_hit      (c_hit),
        .c_pbit     (c_pbit),
        .t_pbit     (tbl_rbit),
        .cache_load (cache_load),
        .grant      (grant),
        .pv         (pv)
    );

    assign prot_valid_n = !(pv && cfg_prot_on);
    assign cyc_en       = grant && addr_strb;
    assign cyc_en_gated = cyc_en && (!cfg_prot_on || !prot_valid_n);
endmodule

// File: rtl/blkprot_chk.sv
`timescale 1ns/1ps
module blkprot_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_xlat_on,
    input logic cfg_prot_on,
    input logic addr_strb,
    input logic xl_done,
    input logic xl_err,
    input logic prot_valid_n,
    input logic cyc_en,
    input logic cyc_en_gated
);
    AST_STRB_LOW_EN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_strb |-> (!cyc_en && !cyc_en_gated)); // R2

    AST_XERR_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_xlat_on && addr_strb && xl_err && !cyc_en) |=> !cyc_en); // R3

    AST_XONLY_RISE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cyc_en) && cfg_xlat_on && !cfg_prot_on) |-> $past(xl_done)); // R3

    AST_EN_AFTER_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_prot_on && cyc_en) |-> !prot_valid_n); // R8

    AST_PV_HIGH_NO_PROT: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_prot_on |-> prot_valid_n); // R9

    AST_GATED_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_en_gated |-> cyc_en); // R10
endmodule

bind blkprot_gate blkprot_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_xlat_on  (cfg_xlat_on),
    .cfg_prot_on  (cfg_prot_on),
    .addr_strb    (addr_strb),
    .xl_done      (xl_done),
    .xl_err       (xl_err),
    .prot_valid_n (prot_valid_n),
    .cyc_en       (cyc_en),
    .cyc_en_gated (cyc_en_gated)
);

// File: tb/blkprot_gate_tb.sv
`timescale 1ns/1ps
module blkprot_gate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_xlat_on = 1'b0;
    logic        cfg_prot_on = 1'b0;
    logic        addr_strb = 1'b0;
    logic [19:0] paddr = '0;
    logic        wr = 1'b0;
    logic        xl_done = 1'b0;
    logic        xl_err = 1'b0;
    logic        tbl_we = 1'b0;
    logic [5:0]  tbl_idx = '0;
    logic        tbl_bit = 1'b0;
    logic        prot_valid_n;
    logic        cyc_en;
    logic        cyc_en_gated;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    blkprot_gate u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_xlat_on  (cfg_xlat_on),
        .cfg_prot_on  (cfg_prot_on),
        .addr_strb    (addr_strb),
        .paddr        (paddr),
        .wr           (wr),
        .xl_done      (xl_done),
        .xl_err       (xl_err),
        .tbl_we       (tbl_we),
        .tbl_idx      (tbl_idx),
        .tbl_bit      (tbl_bit),
        .prot_valid_n (prot_valid_n),
        .cyc_en       (cyc_en),
        .cyc_en_gated (cyc_en_gated)
    );

    task automatic chk(input string rq, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", rq, what, act, exp, $time);
        end
    endtask

    task automatic set_mode(input logic x, input logic p);
        @(negedge clk);
        cfg_xlat_on = x;
        cfg_prot_on = p;
    endtask

    task automatic tbl_write(input logic [5:0] idx, input logic b);
        @(negedge clk);
        tbl_we  = 1'b1;
        tbl_idx = idx;
        tbl_bit = b;
        @(negedge clk);
        tbl_we  = 1'b0;
    endtask

    // grant_at = 0 means the access must never be enabled.
    task automatic do_access(input string rq, input logic w, input logic [19:0] a,
                             input logic xd, input logic xe, input int grant_at,
                             input int span, input logic exp_pv);
        @(negedge clk);
        addr_strb = 1'b1;
        wr        = w;
        paddr     = a;
        xl_done   = xd;
        xl_err    = xe;
        for (int i = 1; i <= span; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk(rq, "cyc_en", cyc_en, (grant_at != 0) && (i >= grant_at));
            chk(rq, "cyc_en_gated (R10)", cyc_en_gated, (grant_at != 0) && (i >= grant_at));
        end
        chk(rq, "prot_valid_n (R9)", prot_valid_n, exp_pv);
        addr_strb = 1'b0;
        xl_done   = 1'b0;
        xl_err    = 1'b0;
        #1;
        chk("R2", "cyc_en after strobe drop", cyc_en, 1'b0);
        chk("R2", "cyc_en_gated after strobe drop", cyc_en_gated, 1'b0);
        @(posedge clk);
        @(negedge clk);
        chk("R9", "prot_valid_n back high", prot_valid_n, 1'b1);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1", "cyc_en in reset", cyc_en, 1'b0);
        chk("R1", "prot_valid_n in reset", prot_valid_n, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "cyc_en after reset", cyc_en, 1'b0);
        chk("R1", "cyc_en_gated after reset", cyc_en_gated, 1'b0);
        chk("R1", "prot_valid_n after reset", prot_valid_n, 1'b1);
    endtask

    task automatic t_neither;
        set_mode(1'b0, 1'b0);
        do_access("R11", 1'b1, 20'h14000, 1'b0, 1'b0, 1, 3, 1'b1);
    endtask

    task automatic t_xlat_only;
        set_mode(1'b1, 1'b0);
        do_access("R3", 1'b1, 20'h00100, 1'b1, 1'b0, 2, 3, 1'b1);
        do_access("R3", 1'b0, 20'h00100, 1'b0, 1'b1, 0, 5, 1'b1);
        // Late validation: enable follows the edge after xl_done.
        @(negedge clk);
        addr_strb = 1'b1;
        wr        = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R3", "cyc_en before validation", cyc_en, 1'b0);
        end
        xl_done = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R3", "cyc_en after late validation", cyc_en, 1'b1);
        addr_strb = 1'b0;
        xl_done   = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_prot_only;
        set_mode(1'b0, 1'b1);
        tbl_write(6'd5, 1'b1);
        do_access("R7", 1'b0, 20'h14000, 1'b0, 1'b0, 3, 4, 1'b0); // miss, read allowed
        do_access("R7", 1'b1, 20'h17FFF, 1'b0, 1'b0, 0, 4, 1'b0); // hit, write denied
        do_access("R6", 1'b1, 20'h18000, 1'b0, 1'b0, 3, 4, 1'b0); // block cross
        do_access("R5", 1'b1, 20'h1BFFE, 1'b0, 1'b0, 2, 3, 1'b0); // hit
    endtask

    task automatic t_invalidate;
        tbl_write(6'd40, 1'b1);
        do_access("R4", 1'b1, 20'h18000, 1'b0, 1'b0, 3, 4, 1'b0); // miss after write
        tbl_write(6'd6, 1'b1);
        do_access("R4", 1'b1, 20'h18000, 1'b0, 1'b0, 0, 4, 1'b0); // new bit seen
        do_access("R4", 1'b1, 20'hA0000, 1'b0, 1'b0, 0, 4, 1'b0); // entry 40
    endtask

    task automatic t_both;
        set_mode(1'b1, 1'b1);
        do_access("R8", 1'b1, 20'h1C000, 1'b1, 1'b0, 4, 5, 1'b0); // miss
        do_access("R8", 1'b1, 20'h1C000, 1'b1, 1'b0, 3, 4, 1'b0); // hit
        do_access("R8", 1'b1, 20'h1C000, 1'b1, 1'b1, 0, 5, 1'b1); // bad translation
        do_access("R8", 1'b1, 20'h18000, 1'b1, 1'b0, 0, 5, 1'b0); // protected
        do_access("R8", 1'b0, 20'h18000, 1'b1, 1'b0, 3, 4, 1'b0); // read, hit
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_neither();
        t_xlat_only();
        t_prot_only();
        t_invalidate();
        t_both();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule